// File: doc/BRIEF.md
# Pulse-Triggered Priority Interrupt Controller

This block sits between a set of interrupt sources and a processor core. Each source signals an interrupt by driving its line high for a single clock cycle. The controller latches every such pulse as a pending bit. The core can also inject a software trap: it raises a one-cycle trap strobe together with an interrupt number, and that number becomes pending in the same set. The number of lines, the width of the priority field, the fixed priority of each line and the set of lines treated as non-maskable are all parameters.

From the pending set the controller picks the most urgent interrupt and presents it to the core. It drives the interrupt number, its priority and a non-maskable flag, and raises a request strobe. Non-maskable interrupts win over all maskable ones. Among the rest a larger priority value wins, and a tie goes to the lowest number. The presented request is frozen until the core pulses the acknowledge for one cycle. That pulse retires the pending bit, and the strobe then drops for at least one cycle before the next request is presented.

Top module: `pulse_irq_ctrl`

## Requirements
- R1: After reset `reqValid`, `reqNum`, `reqPrio` and `reqNmi` are all 0 and no interrupt is pending.
- R2: A one-cycle pulse on `irqPulse[i]` becomes pending at the clock edge that samples it. When the controller is idle with nothing else pending, `reqValid` rises at the next edge after that one.
- R3: While `reqValid` is high, `reqNum` is the presented line number. `reqPrio` is that line's entry in `LINE_PRIO` (bits `i*PRIO_W +: PRIO_W`), and `reqNmi` equals `NMI_MASK[i]`.
- R4: While `reqValid` is high and `ack` is low, `reqValid`, `reqNum`, `reqPrio` and `reqNmi` stay unchanged. This holds even if a more urgent interrupt becomes pending.
- R5: `ack` sampled high while `reqValid` is high clears the presented pending bit and drops `reqValid` at that edge. `reqValid` stays low for at least one cycle, and any remaining pending interrupt is presented at the following edge.
- R6: Arbitration ranks pending interrupts first by the non-maskable flag, then by larger priority value, then by lower line number.
- R7: `trapReq` high for one cycle with `trapNum` = n marks interrupt n pending, exactly as a pulse on line n would. A number of `NUM_LINES` or above is ignored.
- R8: Further pulses on a line that is already pending merge into the single pending bit and cause only one request.
- R9: `ack` sampled while `reqValid` is low has no effect on the pending set or the outputs.
- R10: If a new pulse or trap for the presented number arrives in the same cycle as its `ack`, the new event wins. The interrupt stays pending and is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irqPulse | input | NUM_LINES | One-cycle interrupt pulses, one bit per line |
| trapReq | input | 1 | One-cycle trap strobe from the core |
| trapNum | input | ID_W | Interrupt number carried by the trap strobe |
| ack | input | 1 | One-cycle acknowledge from the core |
| reqValid | output | 1 | Request strobe to the core |
| reqNum | output | ID_W | Number of the presented interrupt |
| reqPrio | output | PRIO_W | Priority of the presented interrupt |
| reqNmi | output | 1 | Non-maskable flag of the presented interrupt |

## Verification
A pulse or trap becomes pending at the edge that samples it. If the controller is idle, the request shows at the ports one edge later. After an acknowledge edge the strobe reads low, and a remaining pending interrupt reads high again one edge after that. The bench drives every input and samples every output on the falling clock edge. It counts falling edges against these latencies, so each check falls half a cycle after the edge that makes the result due. It also checks the cycle before, where the strobe must still be low or must still hold its frozen value.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // capture the arbitration winner into the output holds
    logic clear;  // retire the pending bit of the held interrupt
  } picCtrl_t;
endpackage

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 3,
  parameter int ID_W      = 3,
  parameter logic [NUM_LINES*PRIO_W-1:0] LINE_PRIO = '0,
  parameter logic [NUM_LINES-1:0]        NMI_MASK  = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqPulse,
  input  logic                 trapReq,
  input  logic [ID_W-1:0]      trapNum,
  input  picCtrl_t             ctrl,
  output logic                 anyPending,
  output logic [ID_W-1:0]      reqNum,
  output logic [PRIO_W-1:0]    reqPrio,
  output logic                 reqNmi
);
  localparam int KEY_W = PRIO_W + 1;

  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] setMask;
  logic [NUM_LINES-1:0] clrMask;
  logic [KEY_W-1:0]     lineKey [NUM_LINES];

  // Urgency key per line: non-maskable flag above the priority value
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_key
    assign lineKey[i] = {NMI_MASK[i], LINE_PRIO[i*PRIO_W +: PRIO_W]};
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      setMask[i] = irqPulse[i] | (trapReq && (trapNum == ID_W'(i)));
      clrMask[i] = ctrl.clear && (reqNum == ID_W'(i));
    end
  end

  // A new event in the acknowledge cycle outlives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~clrMask) | setMask;
  end

  assign anyPending = |pending;

  // Ascending scan, strict compare: ties keep the lower number
  logic                 bestFound;
  logic [KEY_W-1:0]     bestKey;
  logic [ID_W-1:0]      bestIdx;
  always_comb begin
    bestFound = 1'b0;
    bestKey   = '0;
    bestIdx   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pending[i] && (!bestFound || lineKey[i] > bestKey)) begin
        bestFound = 1'b1;
        bestKey   = lineKey[i];
        bestIdx   = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqNum  <= '0;
      reqPrio <= '0;
      reqNmi  <= 1'b0;
    end else if (ctrl.load) begin
      reqNum  <= bestIdx;
      reqPrio <= bestKey[PRIO_W-1:0];
      reqNmi  <= bestKey[KEY_W-1];
    end
  end
endmodule

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     anyPending,
  input  logic     ack,
  output picCtrl_t ctrl,
  output logic     reqValid
);
  typedef enum logic {ST_IDLE, ST_BUSY} picState_e;
  picState_e state, stateNext;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (anyPending) begin
        ctrl.load = 1'b1;
        stateNext = ST_BUSY;
      end
      ST_BUSY: if (ack) begin
        ctrl.clear = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign reqValid = (state == ST_BUSY);
endmodule

// File: rtl/pulse_irq_ctrl.sv
module pulse_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 3,
  parameter logic [NUM_LINES*PRIO_W-1:0] LINE_PRIO =
    {3'd5, 3'd2, 3'd7, 3'd0, 3'd5, 3'd3, 3'd3, 3'd1},
  parameter logic [NUM_LINES-1:0] NMI_MASK = 8'b0100_0000,
  localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqPulse,
  input  logic                 trapReq,
  input  logic [ID_W-1:0]      trapNum,
  input  logic                 ack,
  output logic                 reqValid,
  output logic [ID_W-1:0]      reqNum,
  output logic [PRIO_W-1:0]    reqPrio,
  output logic                 reqNmi
);
  picCtrl_t ctrl;
  logic     anyPending;

  pic_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .anyPending (anyPending),
    .ack        (ack),
    .ctrl       (ctrl),
    .reqValid   (reqValid)
  );

  pic_datapath #(
    .NUM_LINES (NUM_LINES),
    .PRIO_W    (PRIO_W),
    .ID_W      (ID_W),
    .LINE_PRIO (LINE_PRIO),
    .NMI_MASK  (NMI_MASK)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .irqPulse   (irqPulse),
    .trapReq    (trapReq),
    .trapNum    (trapNum),
    .ctrl       (ctrl),
    .anyPending (anyPending),
    .reqNum     (reqNum),
    .reqPrio    (reqPrio),
    .reqNmi     (reqNmi)
  );
endmodule

// File: rtl/pulse_irq_ctrl_checker.sv
module pulse_irq_ctrl_checker #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 3,
  parameter int ID_W      = 3,
  parameter logic [NUM_LINES*PRIO_W-1:0] LINE_PRIO = '0,
  parameter logic [NUM_LINES-1:0]        NMI_MASK  = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              reqValid,
  input logic [ID_W-1:0]   reqNum,
  input logic [PRIO_W-1:0] reqPrio,
  input logic              reqNmi
);
  // R4: a request without acknowledge is held unchanged
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !ack) |=> (reqValid && $stable(reqNum) && $stable(reqPrio) && $stable(reqNmi)));

  // R5: an acknowledged request drops for at least one cycle
  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && ack) |=> !reqValid);

  // R3: presented priority matches the line's configured value
  a_r3_prio_of_line: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (reqPrio == LINE_PRIO[reqNum*PRIO_W +: PRIO_W]));

  // R3: non-maskable flag matches the line's configuration
  a_r3_nmi_of_line: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (reqNmi == NMI_MASK[reqNum]));
endmodule

bind pulse_irq_ctrl pulse_irq_ctrl_checker #(
  .NUM_LINES (NUM_LINES),
  .PRIO_W    (PRIO_W),
  .ID_W      (ID_W),
  .LINE_PRIO (LINE_PRIO),
  .NMI_MASK  (NMI_MASK)
) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .reqValid (reqValid),
  .reqNum   (reqNum),
  .reqPrio  (reqPrio),
  .reqNmi   (reqNmi)
);

// File: tb/pulse_irq_ctrl_tb_top.sv
module pulse_irq_ctrl_tb_top;
  localparam int NL = 8;
  localparam int PW = 3;
  localparam int IW = 3;
  // line priorities 0..7 = 1,3,3,5,0,7,2,5 ; line 6 non-maskable
  localparam logic [NL*PW-1:0] LPRIO = {3'd5, 3'd2, 3'd7, 3'd0, 3'd5, 3'd3, 3'd3, 3'd1};
  localparam logic [NL-1:0]    LNMI  = 8'b0100_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irqPulse = '0;
  logic          trapReq = 1'b0;
  logic [IW-1:0] trapNum = '0;
  logic          ack = 1'b0;
  logic          reqValid;
  logic [IW-1:0] reqNum;
  logic [PW-1:0] reqPrio;
  logic          reqNmi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pulse_irq_ctrl #(.NUM_LINES(NL), .PRIO_W(PW), .LINE_PRIO(LPRIO), .NMI_MASK(LNMI)) dut_i (
    .clk(clk), .rst_n(rst_n), .irqPulse(irqPulse), .trapReq(trapReq), .trapNum(trapNum),
    .ack(ack), .reqValid(reqValid), .reqNum(reqNum), .reqPrio(reqPrio), .reqNmi(reqNmi));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // All drivers start at a falling edge and return at the next one
  task automatic pulse(input logic [NL-1:0] m);
    irqPulse = m; tick(1); irqPulse = '0;
  endtask

  task automatic doAck();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic expectReq(input string tag, input int num, input int prio, input int nmi);
    check({tag, " valid"}, reqValid, 1);
    check({tag, " num"}, reqNum, num);
    check({tag, " prio"}, reqPrio, prio);
    check({tag, " nmi"}, reqNmi, nmi);
  endtask

  task automatic testReset();
    check("R1 valid", reqValid, 0);
    check("R1 num", reqNum, 0);
    check("R1 prio", reqPrio, 0);
    check("R1 nmi", reqNmi, 0);
    tick(2);
    check("R1 nothing pending", reqValid, 0);
  endtask

  task automatic testSingleAndHold();
    pulse(8'b0000_1000);
    check("R2 not early", reqValid, 0);
    tick(1);
    expectReq("R2/R3 line3", 3, 5, 0);
    pulse(8'b0010_0000);  // more urgent line 5 while held
    for (int k = 0; k < 3; k++) begin
      expectReq("R4 hold line3", 3, 5, 0);
      tick(1);
    end
    doAck();
    check("R5 gap", reqValid, 0);
    tick(1);
    expectReq("R5 next line5", 5, 7, 0);
    doAck();
    check("R5 gap2", reqValid, 0);
    tick(2);
    check("R5 retired", reqValid, 0);
  endtask

  task automatic testTies();
    pulse(8'b0000_0111);
    tick(1);
    expectReq("R6 tie low num", 1, 3, 0);
    doAck(); tick(1);
    expectReq("R6 second", 2, 3, 0);
    doAck(); tick(1);
    expectReq("R6 third", 0, 1, 0);
    doAck(); tick(2);
    check("R6 empty", reqValid, 0);
  endtask

  task automatic testNmi();
    pulse(8'b0110_0000);
    tick(1);
    expectReq("R6 nmi first", 6, 2, 1);
    doAck(); tick(1);
    expectReq("R6 after nmi", 5, 7, 0);
    doAck(); tick(2);
    check("R6 nmi empty", reqValid, 0);
  endtask

  task automatic testTrap();
    trapReq = 1'b1; trapNum = 3'd4; tick(1); trapReq = 1'b0; trapNum = '0;
    check("R7 not early", reqValid, 0);
    tick(1);
    expectReq("R7 trap4", 4, 0, 0);
    doAck(); tick(2);
    check("R7 retired", reqValid, 0);
  endtask

  task automatic testMerge();
    pulse(8'b0000_1000);
    tick(1);
    expectReq("R8 line3", 3, 5, 0);
    pulse(8'b1000_0000);
    tick(1);
    pulse(8'b1000_0000);
    doAck(); tick(1);
    expectReq("R8 line7", 7, 5, 0);
    doAck();
    check("R8 gap", reqValid, 0);
    tick(2);
    check("R8 no duplicate", reqValid, 0);
  endtask

  task automatic testIdleAck();
    doAck();
    check("R9 idle ack", reqValid, 0);
    pulse(8'b0000_0010);
    doAck();  // seen while reqValid still low
    expectReq("R9 survives", 1, 3, 0);
    tick(1);
    expectReq("R9 held", 1, 3, 0);
    doAck(); tick(2);
    check("R9 retired", reqValid, 0);
  endtask

  task automatic testCollision();
    pulse(8'b0000_0100);
    tick(1);
    expectReq("R10 line2", 2, 3, 0);
    ack = 1'b1; irqPulse = 8'b0000_0100; tick(1); ack = 1'b0; irqPulse = '0;
    check("R10 gap", reqValid, 0);
    tick(1);
    expectReq("R10 again", 2, 3, 0);
    doAck(); tick(2);
    check("R10 retired", reqValid, 0);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    testReset();
    testSingleAndHold();
    testTies();
    testNmi();
    testTrap();
    testMerge();
    testIdleAck();
    testCollision();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule